// File: doc/BRIEF.md
# Fixed-Point Multiply-Add Unit

This unit performs an integer multiply-add on three operands held in the 82-bit floating-point register image. The layout is: bit 81 is the sign, bits 80:64 are the 17-bit exponent, and bits 63:0 are the significand. The unit uses only the significands. It multiplies the significands of operands A and B, then adds the significand of operand C, zero-extended, to form a 128-bit sum. One 64-bit half of that sum is returned as a register image in canonical integer form. A signed/unsigned select sets how A and B are read. A low/high select picks which half is returned.

The datapath is an iterative shift-add multiplier. It consumes `DIGIT_BITS` bits of B per cycle. A small controller walks it through four named states:

- `S_IDLE` waits for work.
- `S_MULT` accumulates partial products for `64/DIGIT_BITS` cycles.
- `S_FIX` applies the two's-complement correction and the addend, then writes the output register.
- `S_OUT` raises the one-cycle result strobe.

The transitions are as follows:

- accept: `S_IDLE` to `S_MULT`, when `in_valid` and `in_ready` are both high.
- step: `S_MULT` to `S_MULT`, while digits remain.
- last digit: `S_MULT` to `S_FIX`.
- finish: `S_FIX` to `S_OUT`.
- release: `S_OUT` to `S_IDLE`.

If any source operand holds the not-a-thing pattern, that pattern replaces the arithmetic result.

Top module: `imac_unit`

## Requirements
- R1: With `high_half`=0 the output significand equals bits 63:0 of (A×B + C) mod 2^128, where A, B and C are bits 63:0 of `src_a`, `src_b` and `src_c`.
- R2: With `high_half`=1 the output significand equals bits 127:64 of the same 128-bit sum.
- R3: With `signed_mode`=1, A and B are read as two's-complement 64-bit values. With `signed_mode`=0, they are read as unsigned.
- R4: C is zero-extended to 128 bits in both modes, so C bit 63 never propagates into bits 127:64.
- R5: Bits 81:64 of every source are ignored, unless the source matches the not-a-thing pattern.
- R6: A normal result has bit 81 = 0, bits 80:64 = 17'h1003E, and the selected half in bits 63:0.
- R7: If any source equals the not-a-thing pattern, `out_data` equals that pattern. The pattern is bit 81 = 0, bits 80:64 = 17'h1FFFE and bits 63:0 = 0.
- R8: `out_valid` is a one-cycle pulse. It is seen high after the (64/DIGIT_BITS + 2)-th rising edge, counting the accepting edge as the first.
- R9: `in_ready` is low from the edge that accepts an operation until `out_valid` has dropped. `in_valid` pulses seen while `in_ready` is low do not change the result.
- R10: After reset, `in_ready`=1 and `out_valid`=0.
- R11: The low half is identical for signed and unsigned modes given the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can accept an operation |
| src_a | input | 82 | Multiplicand register image |
| src_b | input | 82 | Multiplier register image |
| src_c | input | 82 | Addend register image |
| signed_mode | input | 1 | 1: two's-complement multiplicands |
| high_half | input | 1 | 1: return bits 127:64 |
| out_valid | output | 1 | Result strobe |
| out_data | output | 82 | Result register image |

## Verification
The bench builds the unit with `DIGIT_BITS`=8, giving eight multiply steps and a latency of ten cycles. This keeps each operation short enough for well over a hundred checked operations in one run. It still exercises the shifting of the multiplicand across every digit position and the sign correction applied after the last digit.

Directed cases cover the following:

- all-ones operands in both modes;
- an addend with bit 63 set;
- junk sign and exponent fields;
- each operand carrying the not-a-thing pattern;
- requests issued while the unit is busy.

These run alongside seeded random operands that are compared with a 128-bit reference computed in the bench.

// File: rtl/imac_pkg.sv
package imac_pkg;
    localparam int FR_W  = 82;
    localparam int SIG_W = 64;
    localparam int EXP_W = 17;
    localparam int PROD_W = 2 * SIG_W;

    localparam logic [EXP_W-1:0] EXP_INTEGER = 17'h1003E;
    localparam logic [EXP_W-1:0] EXP_NOTHING = 17'h1FFFE;

    typedef logic [FR_W-1:0]   freg_t;
    typedef logic [SIG_W-1:0]  sig_t;
    typedef logic [PROD_W-1:0] wide_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MULT = 2'd1,
        S_FIX  = 2'd2,
        S_OUT  = 2'd3
    } ctrl_state_t;

    localparam freg_t NOTHING_WORD = {1'b0, EXP_NOTHING, {SIG_W{1'b0}}};

    function automatic freg_t make_integer(input sig_t value);
        return {1'b0, EXP_INTEGER, value};
    endfunction
endpackage

// File: rtl/imac_operand_split.sv
module imac_operand_split
    import imac_pkg::*;
(
    input  freg_t word_i,
    output sig_t  sig_o,
    output logic  nothing_o
);
    // Only the significand feeds the arithmetic. The full word is compared for the marker.
    always_comb begin
        sig_o     = word_i[SIG_W-1:0];
        nothing_o = (word_i == NOTHING_WORD);
    end
endmodule

// File: rtl/imac_ctrl.sv
module imac_ctrl
    import imac_pkg::*;
#(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic step_en,
    output logic fix_en,
    output logic out_valid
);
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    ctrl_state_t state_q, state_d;
    logic [STEP_W-1:0] step_q;

    // State register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_MULT) step_q <= step_q + 1'b1;
            else                   step_q <= '0;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (in_valid)           state_d = S_MULT;
            S_MULT: if (step_q == LAST_STEP) state_d = S_FIX;
            S_FIX:                          state_d = S_OUT;
            S_OUT:                          state_d = S_IDLE;
            default:                        state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = (state_q == S_IDLE);
        load      = (state_q == S_IDLE) && in_valid;
        step_en   = (state_q == S_MULT);
        fix_en    = (state_q == S_FIX);
        out_valid = (state_q == S_OUT);
    end

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid && in_ready));

    // R8
    fix_then_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |=> out_valid);
endmodule

// File: rtl/imac_digit_mult.sv
module imac_digit_mult
    import imac_pkg::*;
#(
    parameter int DIGIT_BITS = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  step_en,
    input  sig_t  mcand_i,
    input  sig_t  mplier_i,
    output wide_t acc_o
);
    wide_t acc_q;
    wide_t mcand_q;
    sig_t  mplier_q;
    wide_t digit_ext;

    always_comb digit_ext = {{(PROD_W-DIGIT_BITS){1'b0}}, mplier_q[DIGIT_BITS-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load) begin
            acc_q    <= '0;
            mcand_q  <= {{SIG_W{1'b0}}, mcand_i};
            mplier_q <= mplier_i;
        end else if (step_en) begin
            acc_q    <= acc_q + mcand_q * digit_ext;
            mcand_q  <= mcand_q << DIGIT_BITS;
            mplier_q <= mplier_q >> DIGIT_BITS;
        end
    end

    always_comb acc_o = acc_q;

    // R1
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_o == '0));
endmodule

// File: rtl/imac_unit.sv
module imac_unit
    import imac_pkg::*;
#(
    parameter int DIGIT_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [81:0] src_a,
    input  logic [81:0] src_b,
    input  logic [81:0] src_c,
    input  logic        signed_mode,
    input  logic        high_half,
    output logic        out_valid,
    output logic [81:0] out_data
);
    localparam int STEPS = SIG_W / DIGIT_BITS;

    freg_t srcs [3];
    sig_t  sigs [3];
    logic  nothing [3];

    always_comb begin
        srcs[0] = src_a;
        srcs[1] = src_b;
        srcs[2] = src_c;
    end

    for (genvar i = 0; i < 3; i++) begin : g_split
        imac_operand_split u_split (
            .word_i    (srcs[i]),
            .sig_o     (sigs[i]),
            .nothing_o (nothing[i])
        );
    end

    logic load, step_en, fix_en;

    imac_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .load      (load),
        .step_en   (step_en),
        .fix_en    (fix_en),
        .out_valid (out_valid)
    );

    wide_t acc;

    imac_digit_mult #(.DIGIT_BITS(DIGIT_BITS)) u_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step_en  (step_en),
        .mcand_i  (sigs[0]),
        .mplier_i (sigs[1]),
        .acc_o    (acc)
    );

    // Captured operation attributes
    sig_t  op_a_q, op_b_q, op_c_q;
    logic  sgn_q, hi_q, nat_q;
    freg_t out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a_q <= '0;
            op_b_q <= '0;
            op_c_q <= '0;
            sgn_q  <= 1'b0;
            hi_q   <= 1'b0;
            nat_q  <= 1'b0;
        end else if (load) begin
            op_a_q <= sigs[0];
            op_b_q <= sigs[1];
            op_c_q <= sigs[2];
            sgn_q  <= signed_mode;
            hi_q   <= high_half;
            nat_q  <= nothing[0] | nothing[1] | nothing[2];
        end
    end

    // Sign correction: subtract 2^64 times the other operand for each negative multiplicand.
    wide_t corr_a, corr_b, final_sum;
    sig_t  half_sel;

    always_comb begin
        corr_a    = (sgn_q && op_a_q[SIG_W-1]) ? {op_b_q, {SIG_W{1'b0}}} : '0;
        corr_b    = (sgn_q && op_b_q[SIG_W-1]) ? {op_a_q, {SIG_W{1'b0}}} : '0;
        final_sum = acc - corr_a - corr_b + {{SIG_W{1'b0}}, op_c_q};
        half_sel  = hi_q ? final_sum[PROD_W-1:SIG_W] : final_sum[SIG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out_q <= '0;
        else if (fix_en) out_q <= nat_q ? NOTHING_WORD : make_integer(half_sel);
    end

    always_comb out_data = out_q;

    // R6
    canonical_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !nat_q) |-> (out_data[81:64] == {1'b0, EXP_INTEGER}));

    // R7
    nothing_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nat_q) |-> (out_data == NOTHING_WORD));

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid));
endmodule

// File: tb/imac_unit_bench.sv
`timescale 1ns/1ps
module imac_unit_bench;
    localparam int DIGIT = 8;
    localparam int LAT   = 64 / DIGIT + 2;
    localparam logic [81:0] NAT_W = {1'b0, 17'h1FFFE, 64'h0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [81:0] src_a = '0, src_b = '0, src_c = '0;
    logic signed_mode = 1'b0, high_half = 1'b0;
    logic out_valid;
    logic [81:0] out_data;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    imac_unit #(.DIGIT_BITS(DIGIT)) u_imac_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .signed_mode(signed_mode), .high_half(high_half),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] ref_half(input logic [63:0] a, input logic [63:0] b,
                                             input logic [63:0] c, input bit sgn, input bit hi);
        logic [127:0] ea, eb, s;
        ea = sgn ? {{64{a[63]}}, a} : {64'h0, a};
        eb = sgn ? {{64{b[63]}}, b} : {64'h0, b};
        s  = ea * eb + {64'h0, c};
        return hi ? s[127:64] : s[63:0];
    endfunction

    task automatic check(input string req, input logic [81:0] act, input logic [81:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation; optionally poke in_valid with junk while busy (R9).
    task automatic run_op(input string req, input logic [81:0] a, input logic [81:0] b,
                          input logic [81:0] c, input bit sgn, input bit hi,
                          input logic [81:0] exp, input bit poke, output logic [63:0] got);
        int n;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        src_a = a; src_b = b; src_c = c; signed_mode = sgn; high_half = hi; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n = 1;
        if (poke) begin
            check("R9 ready low while busy", {81'h0, in_ready}, 82'h0);
            src_a = ~a; src_b = 82'h5; src_c = 82'h7; signed_mode = ~sgn; high_half = ~hi;
            in_valid = 1'b1;
        end
        while (!out_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        check({req, " R8 latency"}, 82'(n), 82'(LAT));
        check(req, out_data, exp);
        got = out_data[63:0];
        @(negedge clk);
        check("R8 pulse ends", {81'h0, out_valid}, 82'h0);
        check("R9 ready after result", {81'h0, in_ready}, 82'h1);
    endtask

    function automatic logic [81:0] canon(input logic [63:0] v);
        return {1'b0, 17'h1003E, v};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, c, lo_s, lo_u, g;
        int seed;
        seed = 32'h1D2C3B;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R10
        check("R10 ready at reset", {81'h0, in_ready}, 82'h1);
        check("R10 valid at reset", {81'h0, out_valid}, 82'h0);
        rst_n = 1'b1;

        // R1 / R6 small values
        run_op("R1 R6 small", canon(64'd7), canon(64'd9), canon(64'd5), 1'b0, 1'b0,
               canon(64'd68), 1'b0, g);
        // R2 R3 all ones unsigned high
        a = '1;
        run_op("R2 R3 unsigned high", canon(a), canon(a), canon(0), 1'b0, 1'b1,
               canon(64'hFFFFFFFFFFFFFFFE), 1'b0, g);
        // R3 signed: (-1)*(-1) high half is 0
        run_op("R3 signed high", canon(a), canon(a), canon(0), 1'b1, 1'b1,
               canon(64'h0), 1'b0, g);
        // R3 signed negative product high half all ones
        run_op("R3 signed neg high", canon(a), canon(64'd3), canon(0), 1'b1, 1'b1,
               canon(64'hFFFFFFFFFFFFFFFF), 1'b0, g);
        // R4 addend bit 63 not sign-extended in signed mode
        run_op("R4 zero-extend", canon(0), canon(0), canon(64'h8000000000000000), 1'b1, 1'b1,
               canon(64'h0), 1'b0, g);
        run_op("R4 zero-extend low", canon(0), canon(0), canon(64'h8000000000000000), 1'b1, 1'b0,
               canon(64'h8000000000000000), 1'b0, g);
        // R5 junk sign/exponent on sources
        run_op("R5 ignore fields", {1'b1, 17'h0ABCD, 64'd100}, {1'b1, 17'h1FFFF, 64'd3},
               {1'b0, 17'h00001, 64'd1}, 1'b0, 1'b0, canon(64'd301), 1'b0, g);
        // R7 not-a-thing in each position
        run_op("R7 nat a", NAT_W, canon(64'd2), canon(64'd3), 1'b0, 1'b0, NAT_W, 1'b0, g);
        run_op("R7 nat b", canon(64'd2), NAT_W, canon(64'd3), 1'b1, 1'b1, NAT_W, 1'b0, g);
        run_op("R7 nat c", canon(64'd2), canon(64'd3), NAT_W, 1'b0, 1'b1, NAT_W, 1'b0, g);
        // R9 poke while busy
        run_op("R9 ignored while busy", canon(64'd11), canon(64'd13), canon(64'd1), 1'b0, 1'b0,
               canon(64'd144), 1'b1, g);

        // Random mix
        for (int i = 0; i < 120; i++) begin
            bit s, h;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = {$urandom, $urandom};
            s = 1'($urandom);
            h = 1'($urandom);
            run_op(h ? "R2 R3 random" : "R1 R3 random", canon(a), canon(b), canon(c), s, h,
                   canon(ref_half(a, b, c, s, h)), (i % 17) == 0, g);
            if (i % 10 == 0) begin
                run_op("R11 low signed", canon(a), canon(b), canon(c), 1'b1, 1'b0,
                       canon(ref_half(a, b, c, 1'b0, 1'b0)), 1'b0, lo_s);
                run_op("R11 low unsigned", canon(a), canon(b), canon(c), 1'b0, 1'b0,
                       canon(ref_half(a, b, c, 1'b0, 1'b0)), 1'b0, lo_u);
                check("R11 halves equal", {18'h0, lo_s}, {18'h0, lo_u});
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule